// File: doc/BRIEF.md
# Parity-Checked Substitution Round Stage

This block is one byte-wide slice of a simplified block-cipher round. It adds a plaintext byte to a key byte (bitwise XOR), passes the sum through the AES substitution box and captures the substituted byte in an output register. The substitution box is built from combinational logic: a Galois-field inverse followed by the affine map.

Both operands arrive with their own even-parity check bit. The sum therefore travels as a 9-bit codeword, and its check bit is the XOR of the two operand check bits. The stage checks that codeword before substitution. It then predicts the parity of the substituted byte through a separate function and checks the produced byte against that prediction.

If either check fails, the register captures a fixed error word and an error flag is raised. The output register returns to zero in every cycle that has no new operation, so each operation starts from the same register state.

Top module: `sbox_parity_stage`

## Requirements
- R1: One clock edge after `start` is sampled high with consistent parity, `res[7:0]` equals the AES S-box of `pt ^ key`.
- R2: Parity is even. An operand check bit equals the XOR of its eight data bits. The codeword check bit is `pt_par ^ key_par`. If it differs from the XOR of the bits of `pt ^ key` when `start` is sampled, the next `res` is the error word.
- R3: A result word that is not the error word carries the even parity of `res[7:0]` in `res[8]`. That bit comes from a parity-prediction function separate from the substitution logic. If it disagrees with the produced byte, the error word is output.
- R4: The error word is 9'h001: bits 8..1 are zero and bit 0 is one.
- R5: After any edge at which `start` is low, `res` is 9'h000. Starts on consecutive edges each load their own result, with no zero cycle between them.
- R6: `err` rises in the same cycle as the error word. It holds its value across edges without `start`, and clears at the next start whose checks pass.
- R7: While `rst_n` is low, `res` is 9'h000 and `err` is 0. Operand values presented with `start` low have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one operation this cycle |
| pt | input | 8 | Plaintext byte |
| pt_par | input | 1 | Even check bit of `pt` |
| key | input | 8 | Key byte |
| key_par | input | 1 | Even check bit of `key` |
| res | output | 9 | Registered result {parity, byte} or the error word |
| err | output | 1 | Error flag of the last operation |

## Verification
Two register behaviours can fall on the same edge: the return-to-zero of the result register and the load of a new operation. The bench provokes this with starts on consecutive cycles and checks that each cycle shows its own fresh result, not a zero. The bench also places a failing-parity start directly before a passing one, and the reverse. This checks that the error word and the flag appear on the edge of the bad operation and that the flag drops exactly on the next good one. A reference model in the bench computes the S-box by brute-force inverse search and is compared on every cycle.

// File: rtl/sbox_parity_stage.sv
module sbox_parity_stage #(
  parameter int W = 8,
  parameter logic [W:0] ERR_WORD = 9'h001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] pt,
  input  logic         pt_par,
  input  logic [W-1:0] key,
  input  logic         key_par,
  output logic [W:0]   res,
  output logic         err
);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] a2, a3, a12, a15, a240;
    a2   = gmul(a, a);
    a3   = gmul(a2, a);
    a12  = gmul(gmul(a3, a3), gmul(a3, a3));
    a15  = gmul(a12, a3);
    a240 = gmul(a15, a15);
    a240 = gmul(a240, a240);
    a240 = gmul(a240, a240);
    a240 = gmul(a240, a240);
    return gmul(gmul(a240, a12), a2);
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] v, s;
    v = ginv(a);
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  // affine map adds each inverse bit five times and the constant has even weight,
  // so the output parity equals the parity of the field inverse
  function automatic logic sbox_par(input logic [7:0] a);
    return ^ginv(a);
  endfunction

  logic [W-1:0] sum, sub;
  logic         sum_par, pred_par, in_bad, out_bad;

  assign sum      = pt ^ key;
  assign sum_par  = pt_par ^ key_par;
  assign in_bad   = (^sum) ^ sum_par;
  assign sub      = sbox(sum);
  assign pred_par = sbox_par(sum);
  assign out_bad  = (^sub) ^ pred_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      err <= 1'b0;
    end else if (start) begin
      res <= (in_bad || out_bad) ? ERR_WORD : {pred_par, sub};
      err <= in_bad || out_bad;
    end else begin
      res <= '0;
    end
  end

endmodule

module sbox_parity_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] pt,
  input logic       pt_par,
  input logic [7:0] key,
  input logic       key_par,
  input logic [8:0] res,
  input logic       err
);
  // R2
  in_parity_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && ((^(pt ^ key)) != (pt_par ^ key_par)) |=> (res == 9'h001) && err);
  // R3
  res_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res != 9'h001) |-> (^res) == 1'b0);
  // R4
  err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && $rose(err) |-> res == 9'h001);
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> res == 9'h000);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(err));
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && ((^(pt ^ key)) == (pt_par ^ key_par)) |=> !err);
endmodule

bind sbox_parity_stage sbox_parity_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pt(pt), .pt_par(pt_par),
  .key(key), .key_par(key_par), .res(res), .err(err)
);

// File: tb/sbox_parity_stage_bench.sv
module sbox_parity_stage_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pt = '0, key = '0;
  logic       pt_par = 1'b0, key_par = 1'b0;
  logic [8:0] res;
  logic       err;

  int runs = 0, fails = 0;
  logic [8:0] m_res = '0;
  logic       m_err = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sbox_parity_stage u_sbox_parity_stage (
    .clk(clk), .rst_n(rst_n), .start(start), .pt(pt), .pt_par(pt_par),
    .key(key), .key_par(key_par), .res(res), .err(err)
  );

  function automatic int fmul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p ^= a;
      a = a << 1;
      if (a > 255) a ^= 'h11b;
    end
    return p;
  endfunction

  function automatic int ref_sbox(int x);
    int inv = 0, s = 'h63;
    for (int c = 1; c < 256; c++) if (fmul(x, c) == 1) inv = c;
    for (int r = 0; r < 5; r++) s ^= ((inv << r) | (inv >> (8 - r))) & 'hff;
    return s;
  endfunction

  function automatic bit par8(int v);
    return ^v[7:0];
  endfunction

  task automatic check(string tag);
    runs++;
    if (res !== m_res || err !== m_err) begin
      fails++;
      $display("FAIL %s: res=%h err=%b expected res=%h err=%b", tag, res, err, m_res, m_err);
    end
  endtask

  task automatic step(bit s, int p, int k, bit pbad, bit kbad, string tag);
    @(negedge clk);
    start = s; pt = p[7:0]; key = k[7:0];
    pt_par = par8(p) ^ pbad; key_par = par8(k) ^ kbad;
    @(posedge clk);
    if (s) begin
      if (pbad ^ kbad) begin
        m_res = 9'h001; m_err = 1'b1;
      end else begin
        int v = ref_sbox((p ^ k) & 'hff);
        m_res = {par8(v), v[7:0]}; m_err = 1'b0;
      end
    end else m_res = '0;
    #1 check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    pt = 8'hff; key = 8'h3c; start = 1'b1;
    #23 check("R7 reset");
    @(negedge clk) rst_n = 1'b1; start = 1'b0;
    step(1, 'h00, 'h00, 0, 0, "R1 S(00)");
    step(1, 'h01, 'h00, 0, 0, "R1 S(01) back-to-back R5");
    step(1, 'h5a, 'h09, 0, 0, "R1 S(53)");
    step(0, 'h12, 'h34, 0, 0, "R5 idle zero");
    step(1, 'h80, 'h80, 1, 0, "R2 pt parity bad R4");
    step(0, 'hff, 'h00, 1, 1, "R6 err held R7 idle");
    step(1, 'hc3, 'h11, 0, 0, "R6 err cleared R3");
    step(1, 'h0f, 'hf0, 0, 1, "R2 key parity bad");
    step(1, 'h0f, 'hf0, 1, 1, "R2 both flipped cancel R1");
    for (int i = 0; i < 300; i++) begin
      int p = (i * 37 + 11) & 'hff, k = (i * 91 + 5) & 'hff;
      step((i % 3) != 2, p, k, (i % 7) == 3, 0, "R1 R3 R5 R6 sweep");
    end
    step(0, 0, 0, 0, 0, "R5 final idle");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule